// File: doc/BRIEF.md
# Periodic compare-match timer channel

This block is one 16-bit timer channel with a small synchronous register bus. A prescaler divides the input clock by 1, 4, 16 or 64 to make a count tick. On each tick the counter advances. When the counter equals the compare register on a tick, a match event occurs. The match sets a status flag, can return the counter to zero, and raises an interrupt request when that request is enabled. With the counter cleared on match, the channel gives one event every `compare + 1` ticks, which makes it a periodic tick source.

A separate run register holds one bit per channel and is meant to be shared by several channels. This channel runs while its own bit, chosen by the `RUN_BIT` parameter, is set. The other bits are stored and read back, but they do not affect this channel. The flag is cleared in two steps. First a status read must see the flag set. Then a write with bit 0 at zero clears it.

The register map uses byte offsets on a 5-bit address:
- 0: control (byte)
- 1: mode scratch (byte)
- 2: pin-control scratch (byte)
- 4: interrupt enable (byte)
- 5: status (byte)
- 6: counter (halfword)
- 8: compare (halfword)
- 16: run register (byte)

Top module: `cmt_channel`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: The counter advances only while run-register bit `RUN_BIT` is 1. While that bit is 0 the counter holds its value. The other run-register bits are stored and read back but have no effect on this channel.
- R3: Control bits 2:0 select the tick rate. Value 0 gives one tick per clock, 1 gives one per 4 clocks, 2 gives one per 16 clocks and 3 gives one per 64 clocks. Values 4 to 7 give one tick per clock. The prescaler restarts when the channel stops, so the first increment comes exactly N clocks after the clock edge that sets the run bit, where N is the selected divisor.
- R4: When control bits 7:5 equal 1, a match returns the counter to 0, so the counter cycles 0..C. With any other value the counter runs freely and wraps from 0xFFFF to 0x0000.
- R5: A match is a tick while counter == compare. It sets status bit 0 at that clock edge, whatever the clear mode.
- R6: A status write clears the flag only when bit 0 of the written value is 0 and a status read has returned the flag as 1 since the flag last rose. Otherwise the write leaves the flag unchanged, and writing 1 to bit 0 never changes it.
- R7: If a clearing status write and a match happen at the same clock edge, the flag stays set.
- R8: `irq_o` is 1 exactly while the flag is set and interrupt-enable bit 0 is 1.
- R9: A counter write takes effect at any time, running or stopped, and takes priority over the tick at that edge.
- R10: Offsets 6 and 8 accept only halfword accesses (`half_i`=1). All other offsets accept only byte accesses (`half_i`=0). An access of the wrong width leaves the register unchanged, and a read of the wrong width returns 0.
- R11: The mode and pin-control registers store a written byte and return it on read. They have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the prescaler input |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Register byte offset |
| half_i | input | 1 | Access width: 1 = halfword, 0 = byte |
| wdata_i | input | 16 | Write data; byte writes use bits 7:0 |
| rdata_o | output | 16 | Read data, combinational while `req_i` and not `we_i` |
| irq_o | output | 1 | Interrupt request: compare flag AND interrupt enable |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit run register and `RUN_BIT` = 0. With these values it can check the divide-by-64 alignment and the 0xFFFF wrap directly. It can also check that the seven foreign run bits are ignored. It sets the compare value to 4 at divide-by-1, so match edges fall on known cycles. A status write can then be placed on the exact edge of a match to test that the flag is kept.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_MODE  = 1;
  localparam int unsigned OFS_PINC  = 2;
  localparam int unsigned OFS_IEN   = 4;
  localparam int unsigned OFS_STAT  = 5;
  localparam int unsigned OFS_CNT   = 6;
  localparam int unsigned OFS_CMP   = 8;
  localparam int unsigned OFS_RUN   = 16;

  localparam logic [2:0] CLR_ON_MATCH = 3'd1;
  localparam int unsigned PRE_W = 6;

  // terminal prescaler count for a select value (divisor - 1)
  function automatic logic [PRE_W-1:0] pre_last(input logic [2:0] sel);
    case (sel)
      3'd1:    pre_last = PRE_W'(3);
      3'd2:    pre_last = PRE_W'(15);
      3'd3:    pre_last = PRE_W'(63);
      default: pre_last = '0;
    endcase
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;

  // >= so a select change while running cannot strand the count
  assign tick_o = run_i && (pre_q >= pre_last(sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || tick_o)  pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_on_match_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cmp_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              match_o
);
  assign match_o = tick_i && (cnt_o == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (wr_i)                       cnt_o <= wdata_i;
    else if (match_o && clr_on_match_i)  cnt_o <= '0;
    else if (tick_i)                     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr0_i,
  output logic flag_o,
  output logic armed_o
);
  logic clr;

  // set beats clear; clear needs a prior read that saw the flag
  assign clr = wr0_i && armed_o && !set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o  <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      if (set_i)    flag_o <= 1'b1;
      else if (clr) flag_o <= 1'b0;
      if (clr)                     armed_o <= 1'b0;
      else if (rd_i && flag_o)     armed_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RUN_W   = 8,
  parameter int unsigned RUN_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              half_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              flag_i,
  output logic [2:0]        pre_sel_o,
  output logic              clr_on_match_o,
  output logic              ien_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic              run_o,
  output logic              cnt_wr_o,
  output logic              stat_rd_o,
  output logic              stat_wr0_o
);
  logic [7:0]       ctrl_q, mode_q, pinc_q;
  logic [RUN_W-1:0] run_q;
  logic             is_half, acc_ok, wr, rd;

  assign is_half = (addr_i == ADDR_W'(OFS_CNT)) || (addr_i == ADDR_W'(OFS_CMP));
  assign acc_ok  = req_i && (half_i == is_half);
  assign wr      = acc_ok && we_i;
  assign rd      = acc_ok && !we_i;

  assign pre_sel_o      = ctrl_q[2:0];
  assign clr_on_match_o = (ctrl_q[7:5] == CLR_ON_MATCH);
  assign run_o          = run_q[RUN_BIT];
  assign cnt_wr_o       = wr && (addr_i == ADDR_W'(OFS_CNT));
  assign stat_rd_o      = rd && (addr_i == ADDR_W'(OFS_STAT));
  assign stat_wr0_o     = wr && (addr_i == ADDR_W'(OFS_STAT)) && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      pinc_q <= '0;
      ien_o  <= 1'b0;
      cmp_o  <= '0;
      run_q  <= '0;
    end else if (wr) begin
      case (addr_i)
        ADDR_W'(OFS_CTRL): ctrl_q <= wdata_i[7:0];
        ADDR_W'(OFS_MODE): mode_q <= wdata_i[7:0];
        ADDR_W'(OFS_PINC): pinc_q <= wdata_i[7:0];
        ADDR_W'(OFS_IEN):  ien_o  <= wdata_i[0];
        ADDR_W'(OFS_CMP):  cmp_o  <= wdata_i;
        ADDR_W'(OFS_RUN):  run_q  <= wdata_i[RUN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        ADDR_W'(OFS_CTRL): rdata_o[7:0]       = ctrl_q;
        ADDR_W'(OFS_MODE): rdata_o[7:0]       = mode_q;
        ADDR_W'(OFS_PINC): rdata_o[7:0]       = pinc_q;
        ADDR_W'(OFS_IEN):  rdata_o[0]         = ien_o;
        ADDR_W'(OFS_STAT): rdata_o[0]         = flag_i;
        ADDR_W'(OFS_CNT):  rdata_o            = cnt_i;
        ADDR_W'(OFS_CMP):  rdata_o            = cmp_o;
        ADDR_W'(OFS_RUN):  rdata_o[RUN_W-1:0] = run_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RUN_W   = 8,
  parameter int unsigned RUN_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              half_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [2:0]        pre_sel;
  logic              clr_on_match, ien, run, tick, match, flag, armed;
  logic              cnt_wr, stat_rd, stat_wr0;
  logic [DATA_W-1:0] cnt, cmp;

  cmt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RUN_W(RUN_W), .RUN_BIT(RUN_BIT)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .half_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .flag_i(flag),
    .pre_sel_o(pre_sel), .clr_on_match_o(clr_on_match), .ien_o(ien),
    .cmp_o(cmp), .run_o(run), .cnt_wr_o(cnt_wr),
    .stat_rd_o(stat_rd), .stat_wr0_o(stat_wr0)
  );

  cmt_prescaler u_pre (
    .clk_i, .rst_ni, .run_i(run), .sel_i(pre_sel), .tick_o(tick)
  );

  cmt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .clr_on_match_i(clr_on_match),
    .wr_i(cnt_wr), .wdata_i(wdata_i), .cmp_i(cmp),
    .cnt_o(cnt), .match_o(match)
  );

  cmt_flag u_flag (
    .clk_i, .rst_ni, .set_i(match), .rd_i(stat_rd), .wr0_i(stat_wr0),
    .flag_o(flag), .armed_o(armed)
  );

  assign irq_o = flag && ien;
endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              run,
  input logic              tick,
  input logic              match,
  input logic              flag,
  input logic              armed,
  input logic              ien,
  input logic              cnt_wr,
  input logic              clr_on_match,
  input logic [DATA_W-1:0] cnt
);
  assert_hold_when_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_tick_needs_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> run);

  assert_wrap_to_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && clr_on_match && !cnt_wr) |=> (cnt == '0));

  assert_flag_on_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> flag);

  assert_clear_needs_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag) |-> $past(armed));

  assert_match_keeps_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag) |-> !$past(match));

  assert_irq_needs_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag);

  assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien |-> !irq_o);
endmodule

bind cmt_channel cmt_channel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .irq_o, .run, .tick, .match, .flag, .armed, .ien,
  .cnt_wr, .clr_on_match, .cnt
);

// File: tb/cmt_channel_bench.sv
module cmt_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, half = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  localparam logic [4:0] A_CTRL = 5'd0, A_MODE = 5'd1, A_PINC = 5'd2, A_IEN = 5'd4,
                         A_STAT = 5'd5, A_CNT = 5'd6, A_CMP = 5'd8, A_RUN = 5'd16;

  always #10 clk = ~clk;

  cmt_channel u_cmt_channel (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .half_i(half), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic h, input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; half = h; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic h, output logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; half = h;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    bus_rd(A_CTRL, 0, v); check("R1 ctrl", v, 16'h0);
    bus_rd(A_CNT,  1, v); check("R1 cnt",  v, 16'h0);
    bus_rd(A_CMP,  1, v); check("R1 cmp",  v, 16'h0);
    bus_rd(A_STAT, 0, v); check("R1 stat", v, 16'h0);
    bus_rd(A_RUN,  0, v); check("R1 run",  v, 16'h0);
    bus_rd(A_IEN,  0, v); check("R1 ien",  v, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_access;
    logic [15:0] v;
    bus_wr(A_MODE, 0, 16'h005A); bus_rd(A_MODE, 0, v); check("R11 mode", v, 16'h005A);
    bus_wr(A_PINC, 0, 16'h00C3); bus_rd(A_PINC, 0, v); check("R11 pinc", v, 16'h00C3);
    bus_wr(A_IEN, 1, 16'h0001);  bus_rd(A_IEN, 0, v);  check("R10 ien half write", v, 16'h0);
    bus_wr(A_CNT, 1, 16'h55AA);  bus_rd(A_CNT, 0, v);  check("R10 cnt byte read", v, 16'h0);
    bus_rd(A_CNT, 1, v);                               check("R10 cnt half read", v, 16'h55AA);
    bus_wr(A_CMP, 0, 16'h0077);  bus_rd(A_CMP, 1, v);  check("R10 cmp byte write", v, 16'h0);
    bus_wr(A_CTRL, 0, 16'h0023); bus_rd(A_CTRL, 0, v); check("R10 ctrl byte", v, 16'h0023);
  endtask

  task automatic t_div64;
    logic [15:0] v;
    bus_wr(A_CTRL, 0, 16'h0003); bus_wr(A_CMP, 1, 16'hFFFF); bus_wr(A_CNT, 1, 16'h0);
    bus_wr(A_RUN, 0, 16'h0001);
    repeat (62) @(negedge clk);
    bus_rd(A_CNT, 1, v); check("R3 div64 before tick", v, 16'h0000);
    bus_rd(A_CNT, 1, v); check("R3 div64 after tick",  v, 16'h0001);
    bus_wr(A_RUN, 0, 16'h0000);
  endtask

  task automatic t_div4;
    logic [15:0] v;
    bus_wr(A_CTRL, 0, 16'h0001); bus_wr(A_CNT, 1, 16'h0);
    bus_wr(A_RUN, 0, 16'h0001);
    repeat (2) @(negedge clk);
    bus_rd(A_CNT, 1, v); check("R3 div4 before tick", v, 16'h0000);
    bus_rd(A_CNT, 1, v); check("R3 div4 after tick",  v, 16'h0001);
    bus_wr(A_RUN, 0, 16'h0000);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    bus_wr(A_CTRL, 0, 16'h0000); bus_wr(A_CMP, 1, 16'h0100); bus_wr(A_CNT, 1, 16'hFFFE);
    bus_wr(A_RUN, 0, 16'h0001);
    bus_rd(A_CNT, 1, v); check("R4 free run top", v, 16'hFFFF);
    bus_rd(A_CNT, 1, v); check("R4 free run wrap", v, 16'h0001);
    bus_wr(A_RUN, 0, 16'h0000);
  endtask

  task automatic t_cnt_write;
    logic [15:0] v;
    bus_wr(A_CTRL, 0, 16'h0000); bus_wr(A_CNT, 1, 16'h0);
    bus_wr(A_RUN, 0, 16'h0001);
    bus_wr(A_CNT, 1, 16'h1234);
    bus_rd(A_CNT, 1, v); check("R9 write while running", v, 16'h1235);
    bus_wr(A_RUN, 0, 16'h0000);
    bus_wr(A_CNT, 1, 16'hABCD);
    bus_rd(A_CNT, 1, v); check("R9 write while stopped", v, 16'hABCD);
  endtask

  task automatic t_periodic;
    logic [15:0] v;
    bus_wr(A_IEN, 0, 16'h0001); bus_wr(A_CTRL, 0, 16'h0020);
    bus_wr(A_CMP, 1, 16'h0004); bus_wr(A_CNT, 1, 16'h0);
    check("R8 irq idle", {15'h0, irq}, 16'h0);
    bus_wr(A_RUN, 0, 16'h0001);
    repeat (4) @(negedge clk);
    check("R5 no match yet", {15'h0, irq}, 16'h0);
    @(negedge clk);
    check("R5 match sets flag", {15'h0, irq}, 16'h1);
    bus_rd(A_CNT, 1, v); check("R4 cleared on match", v, 16'h0001);
    bus_wr(A_RUN, 0, 16'h0000);
    bus_rd(A_CNT, 1, v); check("R2 stop value", v, 16'h0004);
    repeat (10) @(negedge clk);
    bus_rd(A_CNT, 1, v); check("R2 held while stopped", v, 16'h0004);
    bus_wr(A_RUN, 0, 16'h00FE);
    bus_rd(A_RUN, 0, v); check("R2 foreign bits stored", v, 16'h00FE);
    repeat (5) @(negedge clk);
    bus_rd(A_CNT, 1, v); check("R2 foreign bits ignored", v, 16'h0004);
    bus_wr(A_RUN, 0, 16'h0000);
  endtask

  task automatic t_flag_clear;
    logic [15:0] v;
    bus_wr(A_IEN, 0, 16'h0000);
    check("R8 enable off", {15'h0, irq}, 16'h0);
    bus_wr(A_IEN, 0, 16'h0001);
    check("R8 enable on", {15'h0, irq}, 16'h1);
    bus_wr(A_STAT, 0, 16'h00FE);
    check("R6 no read no clear", {15'h0, irq}, 16'h1);
    bus_rd(A_STAT, 0, v); check("R5 status bit0", v, 16'h0001);
    bus_wr(A_STAT, 0, 16'h0001);
    check("R6 write one no effect", {15'h0, irq}, 16'h1);
    bus_wr(A_STAT, 0, 16'h00FE);
    check("R6 read then zero clears", {15'h0, irq}, 16'h0);
    bus_rd(A_STAT, 0, v); check("R6 status after clear", v, 16'h0000);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    bus_wr(A_CNT, 1, 16'h0);
    bus_wr(A_RUN, 0, 16'h0001);
    repeat (5) @(negedge clk);
    bus_rd(A_STAT, 0, v); check("R5 flag after period", v, 16'h0001);
    @(negedge clk);
    bus_wr(A_STAT, 0, 16'h00FE);
    check("R7 match wins over clear", {15'h0, irq}, 16'h1);
    bus_wr(A_STAT, 0, 16'h00FE);
    check("R6 later clear succeeds", {15'h0, irq}, 16'h0);
    bus_wr(A_RUN, 0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_access;
    t_div64;
    t_div4;
    t_wrap;
    t_cnt_write;
    t_periodic;
    t_flag_clear;
    t_collide;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule